// File: doc/BRIEF.md
# Prescaled Interval Timer

This block raises a periodic interrupt from a down-counter that a programmable prescaler paces. An 8-bit divide register holds one less than the wanted division ratio. The prescaler counts down from that value and, each time it expires, issues one tick. On each tick the 16-bit count register moves one step. A tick that finds the count at one brings it to zero and pulses the interrupt output. The next tick loads the count again from a separate 16-bit period register, and counting then resumes.

Software writes and reads the count, period and divide registers through plain write strobes with data buses. Each register has its own read-back port. A run input starts and pauses the timer. While run is low, the prescaler and the count keep their values and the registers stay writable. A direct write to the count always takes priority over the timer's own update in that cycle. The reset input is asynchronous and active low. An internal synchronizer releases it in step with the clock.

Top module: `interval_timer`

## Requirements
- R1: After reset the count, period and divide registers read 0 and the interrupt output is low.
- R2: With divide value d, the count takes one step every d+1 cycles in which run is high. Writing the divide register also restarts the prescaler from the written value, so the first step comes on the (d+1)th run cycle after the write. A divide value of 0 gives a step on every run cycle.
- R3: A step that finds the count above 1 lowers it by exactly one.
- R4: A step that finds the count at 1 sets it to 0. In the same cycle in which the count first reads 0, the interrupt output is high, and only for that one cycle.
- R5: A step that finds the count at 0 loads it from the period register and leaves the interrupt output low. A period of 0 therefore holds the count at 0 with no further interrupts.
- R6: A count write is visible on the read-back port in the next cycle. It overrides any step in the same cycle and suppresses that step's interrupt.
- R7: While run is low, neither the count nor the prescaler position changes except through writes, and the interrupt output stays low.
- R8: Period and divide writes show on their read-back ports in the next cycle. A period write does not change the count; it takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Timer enable; low pauses prescaler and count |
| cnt_we | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 16 | Value for the count register |
| cnt_q | output | 16 | Current count |
| per_we | input | 1 | Write strobe for the period register |
| per_wdata | input | 16 | Value for the period register |
| per_q | output | 16 | Current period |
| div_we | input | 1 | Write strobe for the divide register |
| div_wdata | input | 8 | Divide ratio minus one |
| div_q | output | 8 | Current divide value |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
All register writes and count steps take effect at the clock edge that samples them. The count and the interrupt are registered together, so both change one edge after the strobe or the step that causes them. The bench drives inputs on the falling edge and reads the outputs at the next falling edge, half a cycle after the edge that produced them. In the vector walk, run is held high for exactly N rising edges, so the expected step count is floor(N/(d+1)). The bench samples the interrupt at every falling edge in that window, so each one-cycle pulse is counted exactly once.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Action taken by the count register in a given cycle.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_LOAD   = 2'd1,
    ACT_DEC    = 2'd2,
    ACT_RELOAD = 2'd3
  } cnt_act_e;

endpackage

// File: rtl/itmr_rst_sync.sv
module itmr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/itmr_cfg_regs.sv
module itmr_cfg_regs #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [CNT_W-1:0] per_q,
  output logic [DIV_W-1:0] div_q
);

  logic [CNT_W-1:0] per_d;
  logic [DIV_W-1:0] div_d;

  always_comb begin
    per_d = per_q;
    div_d = div_q;
    if (per_we) per_d = per_wdata;
    if (div_we) div_d = div_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      div_q <= '0;
    end else begin
      per_q <= per_d;
      div_q <= div_d;
    end
  end

  a_r8_per_write: assert property (@(posedge clk) disable iff (!rst_n)
    per_we |=> per_q == $past(per_wdata));
  a_r8_per_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !per_we |=> $stable(per_q));
  a_r8_div_write: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> div_q == $past(div_wdata));

endmodule

// File: rtl/itmr_prescaler.sv
module itmr_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick_o
);

  localparam logic [DIV_W-1:0] PRE_ONE = DIV_W'(1);

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_d;
  logic             expired;

  assign expired = (pre_q == '0);
  assign tick_o  = run && expired;

  always_comb begin
    pre_d = pre_q;
    if (div_we)       pre_d = div_wdata;
    else if (run) begin
      if (expired)    pre_d = div_q;
      else            pre_d = pre_q - PRE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_we |=> pre_q == $past(div_wdata));
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !div_we) |=> pre_q == $past(div_q));
  a_r7_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !div_we) |=> $stable(pre_q));
  a_r7_no_tick_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick_o);

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  cnt_act_e         act;
  logic [CNT_W-1:0] cnt_d;
  logic             irq_d;

  always_comb begin
    act = ACT_HOLD;
    if (cnt_we)          act = ACT_LOAD;
    else if (tick) begin
      if (cnt_q == '0)   act = ACT_RELOAD;
      else               act = ACT_DEC;
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    irq_d = 1'b0;
    case (act)
      ACT_LOAD:   cnt_d = cnt_wdata;
      ACT_DEC: begin
        cnt_d = cnt_q - CNT_ONE;
        irq_d = (cnt_q == CNT_ONE);
      end
      ACT_RELOAD: cnt_d = per_q;
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_o <= irq_d;
    end
  end

  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt_q > CNT_ONE) |=> cnt_q == $past(cnt_q) - CNT_ONE);
  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && cnt_q == '0) |=> (cnt_q == $past(per_q)) && !irq_o);
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt_q == $past(cnt_wdata)) && !irq_o);
  a_r4_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cnt_q == '0);
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int CNT_W     = 16,
  parameter int DIV_W     = 8,
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             run,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  input  logic             per_we,
  input  logic [CNT_W-1:0] per_wdata,
  output logic [CNT_W-1:0] per_q,
  input  logic             div_we,
  input  logic [DIV_W-1:0] div_wdata,
  output logic [DIV_W-1:0] div_q,
  output logic             irq
);

  logic rst_n_s;
  logic tick;

  itmr_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  itmr_cfg_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .per_q     (per_q),
    .div_q     (div_q)
  );

  itmr_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run       (run),
    .div_we    (div_we),
    .div_wdata (div_wdata),
    .div_q     (div_q),
    .tick_o    (tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick      (tick),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .per_q     (per_q),
    .cnt_q     (cnt_q),
    .irq_o     (irq)
  );

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!run && !cnt_we) |=> $stable(cnt_q) && !irq);
  a_r8_period_no_touch: assert property (@(posedge clk) disable iff (!rst_n_s)
    (per_we && !run && !cnt_we) |=> cnt_q == $past(cnt_q));

endmodule

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        run;
  logic        cnt_we;
  logic [15:0] cnt_wdata;
  logic [15:0] cnt_q;
  logic        per_we;
  logic [15:0] per_wdata;
  logic [15:0] per_q;
  logic        div_we;
  logic [7:0]  div_wdata;
  logic [7:0]  div_q;
  logic        irq;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  interval_timer i_interval_timer (
    .clk(clk), .arst_n(arst_n), .run(run),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
    .per_we(per_we), .per_wdata(per_wdata), .per_q(per_q),
    .div_we(div_we), .div_wdata(div_wdata), .div_q(div_q),
    .irq(irq)
  );

  typedef struct packed {
    logic [7:0]  d;
    logic [15:0] p;
    logic [15:0] c;
    logic [15:0] n;
    logic [15:0] exp_cnt;
    logic [7:0]  exp_irq;
  } vec_t;

  // d, period, start count, run cycles, expected count, expected pulses
  localparam vec_t VEC [8] = '{
    '{8'd0,   16'd5,      16'd3,  16'd3,   16'd0,      8'd1},
    '{8'd0,   16'd5,      16'd3,  16'd10,  16'd5,      8'd2},
    '{8'd3,   16'd2,      16'd4,  16'd20,  16'd2,      8'd1},
    '{8'd1,   16'd0,      16'd1,  16'd8,   16'd0,      8'd1},
    '{8'd255, 16'd1,      16'd2,  16'd600, 16'd0,      8'd1},
    '{8'd2,   16'd1,      16'd1,  16'd12,  16'd1,      8'd2},
    '{8'd0,   16'hFFFF,   16'd0,  16'd2,   16'hFFFE,   8'd0},
    '{8'd4,   16'd3,      16'd10, 16'd4,   16'd10,     8'd0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_div(input logic [7:0] v);
    div_we = 1'b1; div_wdata = v;
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_per(input logic [15:0] v);
    per_we = 1'b1; per_wdata = v;
    @(negedge clk);
    per_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [15:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    @(negedge clk);
    cnt_we = 1'b0;
  endtask

  // Hold run high for exactly n rising edges, counting interrupt pulses.
  task automatic run_for(input int n, output int pulses);
    pulses = 0;
    run = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (irq) pulses++;
    end
    run = 1'b0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int pulses;
    arst_n = 1'b0; run = 1'b0;
    cnt_we = 1'b0; cnt_wdata = '0;
    per_we = 1'b0; per_wdata = '0;
    div_we = 1'b0; div_wdata = '0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 count", cnt_q, 0);
    check("R1 period", per_q, 0);
    check("R1 divide", div_q, 0);
    check("R1 irq", irq, 0);

    // Vector walk: R2 R3 R4 R5
    foreach (VEC[i]) begin
      wr_div(VEC[i].d);
      wr_per(VEC[i].p);
      wr_cnt(VEC[i].c);
      run_for(int'(VEC[i].n), pulses);
      check($sformatf("R2/R3/R5 vec%0d count", i), cnt_q, VEC[i].exp_cnt);
      check($sformatf("R4 vec%0d pulses", i), pulses, VEC[i].exp_irq);
    end

    // R8: read-back of period and divide, period write leaves count alone
    wr_div(8'd3);
    check("R8 divide readback", div_q, 8'd3);
    wr_cnt(16'd50);
    wr_per(16'h1234);
    check("R8 period readback", per_q, 16'h1234);
    check("R8 count untouched by period write", cnt_q, 16'd50);

    // R7: pause holds both count and prescaler position
    wr_div(8'd3);
    run_for(3, pulses);
    check("R7 no step before d+1 cycles", cnt_q, 16'd50);
    repeat (10) @(negedge clk);
    check("R7 count held while idle", cnt_q, 16'd50);
    check("R7 irq low while idle", irq, 0);
    run_for(1, pulses);
    check("R7 prescaler resumed from held position", cnt_q, 16'd49);

    // R4: exact cycle of the pulse
    wr_div(8'd0);
    wr_cnt(16'd1);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    check("R4 count reaches zero", cnt_q, 0);
    check("R4 irq with zero", irq, 1);
    @(negedge clk);
    check("R4 irq one cycle only", irq, 0);

    // R5: reload uses the new period, no pulse
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    check("R5 reload from new period", cnt_q, 16'h1234);
    check("R5 no irq on reload", irq, 0);

    // R6: write overrides a step in the same cycle
    wr_cnt(16'd1);
    run = 1'b1; cnt_we = 1'b1; cnt_wdata = 16'd7;
    @(negedge clk);
    cnt_we = 1'b0;
    check("R6 write beats step", cnt_q, 16'd7);
    check("R6 no irq on overridden step", irq, 0);
    @(negedge clk);
    run = 1'b0;
    check("R3 step after write", cnt_q, 16'd6);

    finish_run();
  end

endmodule